// File: doc/BRIEF.md
# Page Table Entry Evaluator with Naturally Aligned Contiguous Pages

This block judges one 64-bit entry read during a three-level page-table walk with a 39-bit virtual address. It accepts the entry, the walk level it was read from, the virtual address and three enables. Two of the enables turn on support for contiguous-page (NAPOT) entries and for page memory types. The third is the memory-type enable taken from the environment configuration. From these it decides whether the entry is unusable, points to a lower table, is a usable leaf, or is a misaligned superpage. For a usable leaf it forms the 56-bit physical address and returns the entry's top ten attribute bits. For a pointer it returns the base address of the next table.

The block is wrapped in a valid/ready handshake. A small state machine has two states. `ST_IDLE` offers `in_ready`. The transition *accept* (in_valid while idle) registers the verdict and moves to `ST_HOLD`. `ST_HOLD` presents `out_valid` with the registered result. The transition *release* (out_ready while holding) goes back to `ST_IDLE`. A new entry is taken only in `ST_IDLE`, so each judgement has a latency of one cycle and needs at least two cycles per entry.

Entry layout used throughout: bit 0 V, 1 R, 2 W, 3 X, 4 U, 5 G, 6 A, 7 D, bits 53..10 the 44-bit PPN, bits 60..54 reserved, bits 62..61 the memory-type code, bit 63 the contiguous flag N. Virtual address: bits 11..0 page offset, 20..12 index 0, 29..21 index 1, 38..30 index 2.

Top module: `pte_judge`

## Requirements
- R1: After reset `in_ready`=1 and `out_valid`=0. An entry offered while `in_ready`=1 is accepted on that clock edge. `out_valid` is 1 from the next cycle, and `in_ready` stays 0 while `out_valid` is 1.
- R2: While `out_valid`=1 and `out_ready`=0, `kind_o`, `addr_o` and `ext_o` hold their values. After a cycle with `out_ready`=1, `out_valid` is 0 and `in_ready` is 1.
- R3: `kind_o` encodes 0 invalid, 1 pointer, 2 leaf success, 3 misaligned. An entry with V=0, or with W=1 and R=0, gives kind 0.
- R4: An entry with any of bits 60..54 set, or with memory-type code (bits 62..61) equal to 3, gives kind 0.
- R5: A leaf (any of R, W, X set) gives kind 0 if N is set while `napot_en`=0. It also gives kind 0 if its memory-type code is nonzero while `mtype_en`=0 or `env_mtype`=0.
- R6: An entry with R=W=X=0 that passes R3/R4 is a pointer (kind 1) with `addr_o` = PPN shifted left by 12. It is instead kind 0 when D, A, U or N is set or its memory-type code is nonzero.
- R7: With `napot_en`=1, a leaf at level 1 or 2 with N set gives kind 0, even when its PPN would also be misaligned.
- R8: A leaf at level L in {1,2} whose PPN bits L*9-1..0 are not all zero gives kind 3 with `addr_o`=0.
- R9: An aligned leaf at level L in {1,2} gives kind 2. Its PPN bits L*9-1..0 are replaced by virtual address bits 12+L*9-1..12.
- R10: At level 0 with `napot_en`=1 and N set, PPN bits 3..0 other than 4'b1000 give kind 0. Otherwise the final PPN bits 3..0 are virtual address bits 15..12.
- R11: For kind 2, `addr_o` = {final PPN, virtual address bits 11..0} and `ext_o` = entry bits 63..54. For kinds other than 2, `ext_o`=0, and `addr_o`=0 except for a pointer.
- R12: A `level_i` value of 3 gives kind 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Entry offered |
| in_ready | output | 1 | Block can take an entry |
| pte_i | input | 64 | Page table entry |
| level_i | input | 2 | Walk level the entry came from |
| va_i | input | 39 | Virtual address being translated |
| napot_en | input | 1 | Contiguous-page entries supported |
| mtype_en | input | 1 | Page memory types supported |
| env_mtype | input | 1 | Environment memory-type enable |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| kind_o | output | 2 | Verdict code |
| addr_o | output | 56 | Physical or next-table address |
| ext_o | output | 10 | Attribute bits of a successful leaf |

## Verification
The two checks that can both hold in one cycle are the contiguous-flag rejection of a superpage and the superpage alignment test. A level-1 leaf with N set and a nonzero low PPN provokes both, and the result must be kind 0, never kind 3. Random entries are biased toward clean upper bits, set V, zero low PPN bits and the 4'b1000 pattern, so that this overlap and the pointer/leaf split occur often. Every result is compared with a bench model of the requirements.

// File: rtl/pte_judge_pkg.sv
package pte_judge_pkg;

    typedef enum logic [1:0] {
        KIND_INVALID  = 2'd0,
        KIND_POINTER  = 2'd1,
        KIND_LEAF     = 2'd2,
        KIND_MISALIGN = 2'd3
    } kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } state_e;

    localparam int FLAG_W = 8;
    localparam int RSW_W  = 2;

endpackage

// File: rtl/pte_class.sv
module pte_class
    import pte_judge_pkg::*;
#(
    parameter int PTE_W   = 64,
    parameter int EXT_W   = 10,
    parameter int PPN_W   = 44,
    parameter int IDX_W   = 9,
    parameter int LVL_W   = 2,
    parameter int NUM_LVL = 3,
    parameter int NAPOT_W = 4
) (
    input  logic [PTE_W-1:0] pte,
    input  logic [LVL_W-1:0] level,
    input  logic             napot_en,
    input  logic             mtype_en,
    input  logic             env_mtype,
    output kind_e            kind,
    output logic             napot_fill
);
    localparam int PPN_LSB = FLAG_W + RSW_W;
    localparam int RSV_W   = EXT_W - 3;

    logic [EXT_W-1:0] ext;
    logic [PPN_W-1:0] ppn;
    logic [PPN_W-1:0] low_mask;
    logic [1:0]       mtype;
    logic             nflag, is_ptr, base_bad, ext_bad, leaf_bad, ptr_bad, lvl_bad;

    always_comb begin
        ext   = pte[PTE_W-1 -: EXT_W];
        nflag = ext[EXT_W-1];
        mtype = ext[EXT_W-2 -: 2];
        ppn   = pte[PPN_LSB +: PPN_W];
        for (int i = 0; i < PPN_W; i++) begin
            low_mask[i] = (i < int'(level) * IDX_W);
        end
        is_ptr   = ~(pte[1] | pte[2] | pte[3]);
        lvl_bad  = int'(level) >= NUM_LVL;
        base_bad = ~pte[0] | (pte[2] & ~pte[1]);
        ext_bad  = (ext[RSV_W-1:0] != '0) | (mtype == 2'b11);
        leaf_bad = ~is_ptr & ((nflag & ~napot_en) |
                              ((mtype != 2'b00) & ~(mtype_en & env_mtype)));
        ptr_bad  = is_ptr & (pte[7] | pte[6] | pte[4] | nflag | (mtype != 2'b00));

        kind       = KIND_INVALID;
        napot_fill = 1'b0;
        if (lvl_bad | base_bad | ext_bad | leaf_bad | ptr_bad) begin
            kind = KIND_INVALID;
        end else if (is_ptr) begin
            kind = KIND_POINTER;
        end else if (level != '0) begin
            if (napot_en & nflag) begin
                kind = KIND_INVALID;
            end else if ((ppn & low_mask) != '0) begin
                kind = KIND_MISALIGN;
            end else begin
                kind = KIND_LEAF;
            end
        end else if (napot_en & nflag) begin
            if (ppn[NAPOT_W-1:0] != NAPOT_W'(1 << (NAPOT_W - 1))) begin
                kind = KIND_INVALID;
            end else begin
                kind       = KIND_LEAF;
                napot_fill = 1'b1;
            end
        end else begin
            kind = KIND_LEAF;
        end
    end

endmodule

// File: rtl/pte_addr_form.sv
module pte_addr_form #(
    parameter int PPN_W   = 44,
    parameter int VA_W    = 39,
    parameter int OFF_W   = 12,
    parameter int IDX_W   = 9,
    parameter int LVL_W   = 2,
    parameter int NAPOT_W = 4,
    localparam int VPN_W  = VA_W - OFF_W,
    localparam int PA_W   = PPN_W + OFF_W
) (
    input  logic [PPN_W-1:0] ppn,
    input  logic [VA_W-1:0]  va,
    input  logic [LVL_W-1:0] level,
    input  logic             napot_fill,
    input  logic             pointer,
    output logic [PA_W-1:0]  pa
);
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn_fill;

    assign vpn = va[VA_W-1:OFF_W];

    for (genvar i = 0; i < PPN_W; i++) begin : g_bit
        if (i < VPN_W) begin : g_mix
            logic from_va;
            assign from_va     = (i < int'(level) * IDX_W) | (napot_fill && (i < NAPOT_W));
            assign ppn_fill[i] = from_va ? vpn[i] : ppn[i];
        end else begin : g_keep
            assign ppn_fill[i] = ppn[i];
        end
    end

    assign pa = pointer ? {ppn, {OFF_W{1'b0}}} : {ppn_fill, va[OFF_W-1:0]};

endmodule

// File: rtl/pte_judge.sv
module pte_judge
    import pte_judge_pkg::*;
#(
    parameter int PTE_W   = 64,
    parameter int EXT_W   = 10,
    parameter int PPN_W   = 44,
    parameter int VA_W    = 39,
    parameter int OFF_W   = 12,
    parameter int IDX_W   = 9,
    parameter int LVL_W   = 2,
    parameter int NUM_LVL = 3,
    parameter int NAPOT_W = 4,
    localparam int PA_W   = PPN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PTE_W-1:0] pte_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic [VA_W-1:0]  va_i,
    input  logic             napot_en,
    input  logic             mtype_en,
    input  logic             env_mtype,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [1:0]       kind_o,
    output logic [PA_W-1:0]  addr_o,
    output logic [EXT_W-1:0] ext_o
);
    localparam int PPN_LSB = FLAG_W + RSW_W;

    state_e           state_q, state_d;
    kind_e            kind_c;
    logic             fill_c, accept;
    logic [PA_W-1:0]  pa_c;

    pte_class #(
        .PTE_W(PTE_W), .EXT_W(EXT_W), .PPN_W(PPN_W), .IDX_W(IDX_W),
        .LVL_W(LVL_W), .NUM_LVL(NUM_LVL), .NAPOT_W(NAPOT_W)
    ) u_class (
        .pte(pte_i), .level(level_i), .napot_en(napot_en), .mtype_en(mtype_en),
        .env_mtype(env_mtype), .kind(kind_c), .napot_fill(fill_c)
    );

    pte_addr_form #(
        .PPN_W(PPN_W), .VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
        .LVL_W(LVL_W), .NAPOT_W(NAPOT_W)
    ) u_addr (
        .ppn(pte_i[PPN_LSB +: PPN_W]), .va(va_i), .level(level_i),
        .napot_fill(fill_c), .pointer(kind_c == KIND_POINTER), .pa(pa_c)
    );

    assign accept = in_valid && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_HOLD;
            ST_HOLD: if (out_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_o <= KIND_INVALID;
            addr_o <= '0;
            ext_o  <= '0;
        end else if (accept) begin
            kind_o <= kind_c;
            unique case (kind_c)
                KIND_LEAF: begin
                    addr_o <= pa_c;
                    ext_o  <= pte_i[PTE_W-1 -: EXT_W];
                end
                KIND_POINTER: begin
                    addr_o <= pa_c;
                    ext_o  <= '0;
                end
                default: begin
                    addr_o <= '0;
                    ext_o  <= '0;
                end
            endcase
        end
    end

    assign in_ready  = (state_q == ST_IDLE);
    assign out_valid = (state_q == ST_HOLD);

endmodule

// File: rtl/pte_judge_chk.sv
module pte_judge_chk #(
    parameter int VA_W  = 39,
    parameter int OFF_W = 12,
    parameter int PA_W  = 56,
    parameter int EXT_W = 10,
    parameter int LVL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [LVL_W-1:0] level_i,
    input logic [VA_W-1:0]  va_i,
    input logic             out_valid,
    input logic             out_ready,
    input logic [1:0]       kind_o,
    input logic [PA_W-1:0]  addr_o,
    input logic [EXT_W-1:0] ext_o
);
    AST_ACCEPT_TO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid); // R1
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R1
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(kind_o) && $stable(addr_o) && $stable(ext_o)); // R2
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |=> !out_valid && in_ready); // R2
    AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && kind_o == 2'd1 |-> addr_o[OFF_W-1:0] == '0); // R6
    AST_MISALIGN_NOADDR: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && kind_o == 2'd3 |-> addr_o == '0); // R8
    AST_LEAF_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> kind_o != 2'd2 || addr_o[OFF_W-1:0] == $past(va_i[OFF_W-1:0])); // R11
    AST_EXT_ONLY_LEAF: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && kind_o != 2'd2 |-> ext_o == '0); // R11
    AST_BAD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && level_i == 2'd3 |=> kind_o == 2'd0); // R12
endmodule

bind pte_judge pte_judge_chk #(
    .VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W), .EXT_W(EXT_W), .LVL_W(LVL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .level_i(level_i), .va_i(va_i), .out_valid(out_valid), .out_ready(out_ready),
    .kind_o(kind_o), .addr_o(addr_o), .ext_o(ext_o)
);

// File: tb/sim_pte_judge.sv
module sim_pte_judge;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] pte_i = '0;
    logic [1:0]  level_i = '0;
    logic [38:0] va_i = '0;
    logic        napot_en = 1'b0, mtype_en = 1'b0, env_mtype = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [1:0]  kind_o;
    logic [55:0] addr_o;
    logic [9:0]  ext_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pte_judge u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .pte_i(pte_i), .level_i(level_i), .va_i(va_i), .napot_en(napot_en),
        .mtype_en(mtype_en), .env_mtype(env_mtype), .out_valid(out_valid),
        .out_ready(out_ready), .kind_o(kind_o), .addr_o(addr_o), .ext_o(ext_o)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: run hung, actual=%0d expected=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // model: {kind, addr, ext}
    function automatic logic [67:0] model(logic [63:0] p, logic [1:0] lv, logic [38:0] va,
                                          logic ne, logic me, logic en);
        logic        leaf, invalid;
        logic [43:0] ppn, msk, fp;
        logic [1:0]  pb;
        pb      = p[62:61];
        ppn     = p[53:10];
        leaf    = p[1] | p[2] | p[3];
        invalid = (lv == 2'd3) || !p[0] || (p[2] && !p[1]) || (p[60:54] != 0) || (pb == 2'd3)
               || (leaf && p[63] && !ne) || (leaf && pb != 0 && !(me && en))
               || (!leaf && (p[7] || p[6] || p[4] || p[63] || pb != 0));
        if (invalid) return {2'd0, 56'd0, 10'd0};
        if (!leaf) return {2'd1, ppn, 12'd0, 10'd0};
        if (lv != 0) begin
            if (ne && p[63]) return {2'd0, 56'd0, 10'd0};
            msk = (lv == 2'd1) ? 44'h1FF : 44'h3FFFF;
            if ((ppn & msk) != 0) return {2'd3, 56'd0, 10'd0};
            fp = (ppn & ~msk) | ({17'd0, va[38:12]} & msk);
        end else if (ne && p[63]) begin
            if (ppn[3:0] != 4'b1000) return {2'd0, 56'd0, 10'd0};
            fp = {ppn[43:4], va[15:12]};
        end else begin
            fp = ppn;
        end
        return {2'd2, fp, va[11:0], p[63:54]};
    endfunction

    task automatic run(string req, logic [63:0] p, logic [1:0] lv, logic [38:0] va,
                       logic ne, logic me, logic en);
        logic [67:0] e;
        e = model(p, lv, va, ne, me, en);
        @(negedge clk);
        pte_i = p; level_i = lv; va_i = va;
        napot_en = ne; mtype_en = me; env_mtype = en;
        in_valid = 1'b1;
        chk("R1 in_ready idle", 64'(in_ready), 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        pte_i = ~p; va_i = ~va;
        chk("R1 out_valid", 64'(out_valid), 64'd1);
        chk("R1 in_ready busy", 64'(in_ready), 64'd0);
        chk({req, " kind"}, 64'(kind_o), 64'(e[67:66]));
        chk({req, " addr"}, 64'(addr_o), 64'(e[65:10]));
        chk({req, " ext"},  64'(ext_o),  64'(e[9:0]));
        @(negedge clk);
        chk("R2 hold kind", 64'(kind_o), 64'(e[67:66]));
        chk("R2 hold addr", 64'(addr_o), 64'(e[65:10]));
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk("R2 released", 64'({out_valid, in_ready}), 64'b01);
    endtask

    initial begin
        logic [63:0] p;
        logic [38:0] va;
        int unsigned seed;
        seed = $urandom(32'h1F2E3D4C);
        repeat (3) @(negedge clk);
        chk("R1 reset ready", 64'(in_ready), 64'd1);
        chk("R1 reset valid", 64'(out_valid), 64'd0);
        rst_n = 1'b1;
        va = 39'h55_AAAA_B123;

        run("R3 V clear",      64'h0000_0000_0000_000E, 0, va, 1, 1, 1);
        run("R3 W without R",  64'h0000_0000_0000_0005, 0, va, 1, 1, 1);
        run("R4 reserved bit", 64'h0040_0000_0000_0003, 0, va, 1, 1, 1);
        run("R4 mtype 3",      64'h6000_0000_0000_000B, 0, va, 1, 1, 1);
        run("R5 N napot off",  64'h8000_0000_0000_2003, 0, va, 0, 1, 1);
        run("R5 mtype env off",64'h2000_0000_0012_3403, 0, va, 1, 1, 0);
        run("R5 mtype feat off",64'h2000_0000_0012_3403, 0, va, 1, 0, 1);
        run("R11 mtype ok",    64'h2000_0000_0012_3403, 0, va, 1, 1, 1);
        run("R6 pointer",      64'h0000_0ABC_DEF1_2401, 2, va, 1, 1, 1);
        run("R6 pointer A",    64'h0000_0ABC_DEF1_2441, 1, va, 1, 1, 1);
        run("R6 pointer N",    64'h8000_0000_0000_2001, 1, va, 1, 1, 1);
        run("R6 pointer mtype",64'h2000_0000_0000_2001, 1, va, 1, 1, 1);
        run("R7 N superpage misaligned", 64'h8000_0000_0000_2C0F, 1, va, 1, 1, 1);
        run("R7 N superpage aligned",    64'h8000_0000_0080_000F, 1, va, 1, 1, 1);
        run("R8 misaligned L1", 64'h0000_0000_0000_2C0F, 1, va, 1, 1, 1);
        run("R8 misaligned L2", 64'h0000_0000_0400_0003, 2, va, 1, 1, 1);
        run("R9 aligned L1",    64'h0000_0000_0080_000F, 1, va, 1, 1, 1);
        run("R9 aligned L2",    64'h0000_0001_0000_0003, 2, va, 1, 1, 1);
        run("R10 napot bad",    64'h8000_0000_0012_1403, 0, va, 1, 1, 1);
        run("R10 napot ok",     64'h8000_0000_0012_2003, 0, va, 1, 1, 1);
        run("R10 plain L0",     64'h0000_0000_0012_2003, 0, va, 1, 1, 1);
        run("R12 level 3",      64'h0000_0000_0012_2003, 3, va, 1, 1, 1);

        for (int k = 0; k < 400; k++) begin
            int unsigned r;
            r = $urandom;
            p = {$urandom, $urandom};
            va = {$urandom, $urandom};
            if (r[1:0] != 0) p[60:54] = '0;
            if (r[3:2] != 0) p[0] = 1'b1;
            if (r[4]) p[27:10] = '0;
            if (r[5]) p[13:10] = 4'b1000;
            if (r[7:6] == 0) p[3:1] = 3'b000;
            if (r[9:8] == 0) p[7:4] = 4'b0000;
            run("R11 random", p, 2'(r[11:10] % 3), va, r[12] | r[13], r[14] | r[15], r[16] | r[17]);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule